// File: doc/BRIEF.md
# DMA Source Address Generator

This block holds the source address of one DMA channel and moves it by one step each time the channel finishes a transfer. Software-side logic loads a start address. The channel then pulses a transfer strobe once per completed transfer. The control inputs decide three things: whether the address is held, counted up or counted down; whether each step is one byte or one two-byte word; and whether the address is confined to a power-of-two window in its low bits.

When a window of 2^N bytes is selected, only the low N address bits move, and the bits above them are frozen. A step that carries out of the window or borrows out of it still wraps the address to the opposite end of the window. That step also sets a sticky flag, which an explicit clear pulse removes. An enable input decides whether the flag drives the interrupt output. Window codes beyond the address width are reserved: the block treats them as "no window" and reports them on a configuration-error output.

Top module: `dma_src_addr_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `addr` is 0 and `repeat_flag`, `irq` and `config_error` are 0 with all control inputs at 0.
- R2: When `load_en` is high at a rising edge, `addr` equals `load_addr` after that edge, even if `xfer_strobe` is high in the same cycle; that strobe is discarded and cannot set the flag.
- R3: With `step_mode` 2'b00 or 2'b01 (fixed), a strobe leaves `addr` unchanged and never sets `repeat_flag`.
- R4: `step_mode` 2'b10 adds the step and 2'b11 subtracts it; the step is 1 when `word_size` is 0 (byte) and 2 when `word_size` is 1 (word).
- R5: With `repeat_sel` 0, the whole 24-bit address moves and wraps modulo 2^24 without setting `repeat_flag`.
- R6: With `repeat_sel` = N in 1..23, a strobe changes only `addr[N-1:0]`, which wraps modulo 2^N; bits N and above keep their value.
- R7: Inside a window, a strobe whose step carries past the top of the window (increment) or borrows below its bottom (decrement) sets `repeat_flag` after that edge.
- R8: `repeat_flag` stays set until a cycle with `flag_clear` high; if a new overflow and `flag_clear` arrive in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when `repeat_flag` is set and `irq_en` is high.
- R10: `repeat_sel` values 24 to 31 raise `config_error` and behave as `repeat_sel` 0; values 0 to 23 keep `config_error` low.
- R11: With neither `load_en` nor `xfer_strobe` high, `addr` holds; each strobe cycle produces exactly one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Load `load_addr` into the address register |
| load_addr | input | 24 | Start address |
| xfer_strobe | input | 1 | One pulse per completed transfer |
| flag_clear | input | 1 | Clears the sticky overflow flag |
| step_mode | input | 2 | 0x fixed, 10 increment, 11 decrement |
| word_size | input | 1 | 0 byte step (1), 1 word step (2) |
| repeat_sel | input | 5 | Window size N (0 none, 1..23 window, 24..31 reserved) |
| irq_en | input | 1 | Lets the flag drive `irq` |
| addr | output | 24 | Current source address |
| repeat_flag | output | 1 | Sticky window-overflow flag |
| irq | output | 1 | Interrupt request |
| config_error | output | 1 | Reserved window code selected |

## Verification
The assertions take two things for granted. First, the control fields (`step_mode`, `word_size`, `repeat_sel`) are steady in any cycle that carries a strobe. Second, the step that was taken is judged against the window that was in force at that edge. The stimulus keeps to this: it changes control fields only in a cycle that also loads a fresh start address or clears the flag, never together with a strobe, and it always holds reset for several edges before releasing it.

// File: rtl/dsa_pkg.sv
// Package dsa_pkg
// Shared encodings for the DMA source address generator.
// Assumes: step_mode is a 2-bit field whose top bit enables movement.
package dsa_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD_A = 2'b00,
        MODE_HOLD_B = 2'b01,
        MODE_UP     = 2'b10,
        MODE_DOWN   = 2'b11
    } step_mode_e;

    // True when the mode moves the address at all.
    function automatic logic mode_moves(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/dsa_window_decode.sv
// Module dsa_window_decode
// Turns the window-size code into a bit mask of the address bits that may
// move, plus a flag that a real window is active and a reserved-code error.
// Assumes: codes above ADDR_W-1 are reserved and mean "no window".
module dsa_window_decode #(
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 5
) (
    input  logic [SEL_W-1:0]  repeat_sel,
    output logic [ADDR_W-1:0] win_mask,
    output logic              win_on,
    output logic              code_bad
);
    localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(ADDR_W - 1);

    // Classify the code: active window, reserved, or none.
    always_comb begin
        code_bad = (repeat_sel > MAX_CODE);
        win_on   = (repeat_sel != '0) && !code_bad;
    end

    // One mask bit per address bit: movable if no window or below N.
    genvar g;
    generate
        for (g = 0; g < ADDR_W; g++) begin : g_mask
            localparam logic [SEL_W-1:0] BIT_IDX = SEL_W'(g);
            assign win_mask[g] = !win_on || (BIT_IDX < repeat_sel);
        end
    endgenerate

endmodule

// File: rtl/dsa_step_calc.sv
// Module dsa_step_calc
// Computes the address after one step and whether that step leaves the
// window. Purely combinational.
// Assumes: win_mask is a contiguous run of ones from bit 0.
module dsa_step_calc
    import dsa_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        step_mode,
    input  logic              word_size,
    input  logic [ADDR_W-1:0] win_mask,
    input  logic              win_on,
    output logic [ADDR_W-1:0] next_addr,
    output logic              wrap_hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] step_ext;
    logic [EXT_W-1:0] low_ext;
    logic [EXT_W-1:0] mask_ext;
    logic [EXT_W-1:0] up_sum;
    logic [EXT_W-1:0] down_diff;
    logic [EXT_W-1:0] result;
    logic             go_up;
    logic             go_down;
    logic             carry_out;
    logic             borrow_out;

    // Select the step size and the movable low part of the address.
    always_comb begin
        step_ext = word_size ? EXT_W'(2) : EXT_W'(1);
        low_ext  = {1'b0, cur_addr & win_mask};
        mask_ext = {1'b0, win_mask};
    end

    // Both candidate results, with one spare bit for carry and borrow.
    always_comb begin
        up_sum    = low_ext + step_ext;
        down_diff = low_ext - step_ext;
        go_up     = (step_mode == MODE_UP);
        go_down   = (step_mode == MODE_DOWN);
        carry_out  = (up_sum > mask_ext);
        borrow_out = down_diff[EXT_W-1];
    end

    // Merge the frozen upper bits with the moved low bits.
    always_comb begin
        result = go_down ? down_diff : up_sum;
        if (mode_moves(step_mode)) begin
            next_addr = (cur_addr & ~win_mask) | (result[ADDR_W-1:0] & win_mask);
        end else begin
            next_addr = cur_addr;
        end
    end

    // A window overflow needs an active window and a carry or borrow.
    always_comb begin
        wrap_hit = win_on && ((go_up && carry_out) || (go_down && borrow_out));
    end

endmodule

// File: rtl/dsa_wrap_flag.sv
// Module dsa_wrap_flag
// Sticky overflow flag with a clear pulse and an enable-gated interrupt.
// Assumes: a set and a clear in the same cycle leave the flag set.
module dsa_wrap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    input  logic irq_en,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clear_i) begin
            flag_q <= 1'b0;
        end
    end

    // Drive the outputs from the stored flag.
    always_comb begin
        flag_o = flag_q;
        irq_o  = flag_q && irq_en;
    end

endmodule

// File: rtl/dma_src_addr_gen.sv
// Module dma_src_addr_gen
// Source address register for one DMA channel. A load takes priority over a
// transfer strobe; each strobe moves the address by one step, either across
// the full width or inside a power-of-two window in the low bits.
// Assumes: control fields are steady in cycles that carry a strobe.
module dma_src_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              xfer_strobe,
    input  logic              flag_clear,
    input  logic [1:0]        step_mode,
    input  logic              word_size,
    input  logic [SEL_W-1:0]  repeat_sel,
    input  logic              irq_en,
    output logic [ADDR_W-1:0] addr,
    output logic              repeat_flag,
    output logic              irq,
    output logic              config_error
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] stepped;
    logic              win_on;
    logic              wrap_hit;
    logic              take_step;

    dsa_window_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_decode (
        .repeat_sel (repeat_sel),
        .win_mask   (win_mask),
        .win_on     (win_on),
        .code_bad   (config_error)
    );

    dsa_step_calc #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr  (addr_q),
        .step_mode (step_mode),
        .word_size (word_size),
        .win_mask  (win_mask),
        .win_on    (win_on),
        .next_addr (stepped),
        .wrap_hit  (wrap_hit)
    );

    // A strobe only counts when no load competes for the register.
    always_comb begin
        take_step = xfer_strobe && !load_en;
    end

    // Address register: load first, then one step per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_en) begin
            addr_q <= load_addr;
        end else if (take_step) begin
            addr_q <= stepped;
        end
    end

    dsa_wrap_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (take_step && wrap_hit),
        .clear_i (flag_clear),
        .irq_en  (irq_en),
        .flag_o  (repeat_flag),
        .irq_o   (irq)
    );

    // Expose the register.
    always_comb begin
        addr = addr_q;
    end

endmodule

// File: rtl/dma_src_addr_gen_chk.sv
// Module dma_src_addr_gen_chk
// Temporal checks on the address generator ports, bound to every instance.
// Assumes: control fields are steady in strobe cycles.
module dma_src_addr_gen_chk #(
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic              xfer_strobe,
    input logic              flag_clear,
    input logic [1:0]        step_mode,
    input logic              word_size,
    input logic [SEL_W-1:0]  repeat_sel,
    input logic              irq_en,
    input logic [ADDR_W-1:0] addr,
    input logic              repeat_flag,
    input logic              irq,
    input logic              config_error
);
    logic [ADDR_W-1:0] frozen_bits;

    // Independent view of which address bits a window freezes.
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            frozen_bits[i] = (repeat_sel != '0) && (int'(repeat_sel) < ADDR_W)
                             && (i >= int'(repeat_sel));
        end
    end

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> addr == $past(load_addr));

    // R3
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && !load_en && !step_mode[1]) |=> $stable(addr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_strobe && !load_en) |=> $stable(addr));

    // R6
    upper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && !load_en) |=> ((addr ^ $past(addr)) & $past(frozen_bits)) == '0);

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(repeat_flag) |-> $past(xfer_strobe && !load_en && step_mode[1]));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_flag && !flag_clear) |=> repeat_flag);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (repeat_flag && irq_en));

    // R10
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(repeat_sel) >= ADDR_W) |-> config_error);

endmodule

bind dma_src_addr_gen dma_src_addr_gen_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_en      (load_en),
    .load_addr    (load_addr),
    .xfer_strobe  (xfer_strobe),
    .flag_clear   (flag_clear),
    .step_mode    (step_mode),
    .word_size    (word_size),
    .repeat_sel   (repeat_sel),
    .irq_en       (irq_en),
    .addr         (addr),
    .repeat_flag  (repeat_flag),
    .irq          (irq),
    .config_error (config_error)
);

// File: tb/dma_src_addr_gen_bench.sv
`timescale 1ns/1ps
// Bench for dma_src_addr_gen: a vector table walked by one loop, then
// directed checks for reset, priority, stickiness and the interrupt gate.
module dma_src_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [23:0] load_addr = '0;
    logic        xfer_strobe = 1'b0;
    logic        flag_clear = 1'b0;
    logic [1:0]  step_mode = 2'b00;
    logic        word_size = 1'b0;
    logic [4:0]  repeat_sel = '0;
    logic        irq_en = 1'b0;
    logic [23:0] addr;
    logic        repeat_flag;
    logic        irq;
    logic        config_error;

    int applied = 0;
    int miscompares = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_src_addr_gen u_dma_src_addr_gen (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .xfer_strobe(xfer_strobe), .flag_clear(flag_clear), .step_mode(step_mode),
        .word_size(word_size), .repeat_sel(repeat_sel), .irq_en(irq_en),
        .addr(addr), .repeat_flag(repeat_flag), .irq(irq), .config_error(config_error)
    );

    // start, mode, word, sel, strobes, expected addr, expected flag
    localparam int NVEC = 16;
    localparam logic [60:0] VEC [NVEC] = '{
        {24'h000010, 2'b10, 1'b0, 5'd0,  4'd3, 24'h000013, 1'b0},
        {24'h000010, 2'b11, 1'b1, 5'd0,  4'd4, 24'h000008, 1'b0},
        {24'h123456, 2'b00, 1'b1, 5'd0,  4'd5, 24'h123456, 1'b0},
        {24'h123456, 2'b01, 1'b0, 5'd4,  4'd5, 24'h123456, 1'b0},
        {24'h00A0FE, 2'b10, 1'b0, 5'd4,  4'd3, 24'h00A0F1, 1'b1},
        {24'h00A0F2, 2'b11, 1'b1, 5'd4,  4'd2, 24'h00A0FE, 1'b1},
        {24'h5555FC, 2'b10, 1'b1, 5'd8,  4'd2, 24'h555500, 1'b1},
        {24'h400000, 2'b10, 1'b0, 5'd1,  4'd1, 24'h400001, 1'b0},
        {24'h400001, 2'b10, 1'b1, 5'd1,  4'd1, 24'h400001, 1'b1},
        {24'hFFFFFF, 2'b10, 1'b0, 5'd0,  4'd1, 24'h000000, 1'b0},
        {24'h000000, 2'b11, 1'b0, 5'd0,  4'd1, 24'hFFFFFF, 1'b0},
        {24'h7FFFFE, 2'b10, 1'b1, 5'd23, 4'd1, 24'h000000, 1'b1},
        {24'h800000, 2'b11, 1'b0, 5'd23, 4'd1, 24'hFFFFFF, 1'b1},
        {24'h123400, 2'b10, 1'b0, 5'd25, 4'd2, 24'h123402, 1'b0},
        {24'h12FFFF, 2'b10, 1'b0, 5'd24, 4'd1, 24'h130000, 1'b0},
        {24'h0000F0, 2'b10, 1'b0, 5'd4,  4'd0, 24'h0000F0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe_once();
        @(negedge clk) xfer_strobe = 1'b1;
        @(negedge clk) xfer_strobe = 1'b0;
    endtask

    task automatic setup(input logic [23:0] st, input logic [1:0] m, input logic w,
                         input logic [4:0] s);
        @(negedge clk);
        step_mode = m; word_size = w; repeat_sel = s;
        load_en = 1'b1; load_addr = st; flag_clear = 1'b1;
        @(negedge clk);
        load_en = 1'b0; flag_clear = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        check("R1 addr in reset", 32'(addr), 32'h0);
        check("R1 flag in reset", 32'(repeat_flag), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 config_error after reset", 32'(config_error), 32'h0);
        check("R1 addr after reset", 32'(addr), 32'h0);

        // Vector table: R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            logic [60:0] e;
            e = VEC[v];
            setup(e[60:37], e[36:35], e[34], e[33:29]);
            for (int k = 0; k < int'(e[28:25]); k++) strobe_once();
            check($sformatf("R4/R6 vector %0d addr", v), 32'(addr), 32'(e[24:1]));
            check($sformatf("R7 vector %0d flag", v), 32'(repeat_flag), 32'(e[0]));
            check($sformatf("R10 vector %0d config_error", v), 32'(config_error),
                  32'(e[33:29] >= 5'd24));
        end

        // R2: load beats strobe in the same cycle
        setup(24'h00000F, 2'b10, 1'b0, 5'd4);
        @(negedge clk);
        load_en = 1'b1; load_addr = 24'h00010F; xfer_strobe = 1'b1;
        @(negedge clk);
        load_en = 1'b0; xfer_strobe = 1'b0;
        check("R2 load priority addr", 32'(addr), 32'h00010F);
        check("R2 discarded strobe flag", 32'(repeat_flag), 32'h0);

        // R11: idle cycles hold the address
        repeat (3) @(negedge clk);
        check("R11 idle hold", 32'(addr), 32'h00010F);

        // R7 R9 R8: overflow, gate, stickiness, clear
        strobe_once();
        check("R7 wrap addr", 32'(addr), 32'h000100);
        check("R7 wrap flag", 32'(repeat_flag), 32'h1);
        check("R9 irq gated off", 32'(irq), 32'h0);
        irq_en = 1'b1;
        #1;
        check("R9 irq enabled", 32'(irq), 32'h1);
        strobe_once();
        check("R11 single step", 32'(addr), 32'h000101);
        check("R8 sticky flag", 32'(repeat_flag), 32'h1);
        @(negedge clk) flag_clear = 1'b1;
        @(negedge clk) flag_clear = 1'b0;
        check("R8 cleared flag", 32'(repeat_flag), 32'h0);
        check("R9 irq follows clear", 32'(irq), 32'h0);

        // R8: set beats clear in the same cycle
        @(negedge clk);
        load_en = 1'b1; load_addr = 24'h00000F;
        @(negedge clk);
        load_en = 1'b0; xfer_strobe = 1'b1; flag_clear = 1'b1;
        @(negedge clk);
        xfer_strobe = 1'b0; flag_clear = 1'b0;
        check("R8 set over clear", 32'(repeat_flag), 32'h1);

        // R10: reserved top code and largest legal code
        repeat_sel = 5'd31;
        #1 check("R10 code 31 error", 32'(config_error), 32'h1);
        repeat_sel = 5'd23;
        #1 check("R10 code 23 no error", 32'(config_error), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule